// File: doc/BRIEF.md
# Write-Transaction to Packet Bridge

The bridge is a slave on three independent write channels (address, data, response), each with its own valid/ready flow control. It turns every write transaction into one packet on a single valid/ready flit stream: a header flit packed from the address-channel fields, then one payload flit per data beat, with the final payload flit flagged as tail. When the packet has left, or when an oversized transaction has been drained, a single response carrying the transaction's ID is returned.

Two forwarding modes exist, chosen per transaction by a mode input sampled when the address is accepted. In cut-through mode the header goes out first and the data channel stays stalled until that header flit is accepted; beats then pass straight through to the stream. In store-and-forward mode all beats are collected in a local buffer first, then the header and the buffered beats are sent. A burst longer than the buffer is refused in that mode: its beats are accepted and dropped and the response reports an error. Only one transaction is handled at a time, and the stream may stall the bridge in any cycle.

Top module: `wr_pkt_bridge`

## Requirements
- R1: After reset aw_ready is 1, while w_ready, b_valid and pk_valid are 0.
- R2: An item moves on a channel only in a cycle where its valid and ready are both 1; while pk_valid or b_valid is 1 and its ready is 0, that output and its payload fields hold unchanged into the next cycle.
- R3: Once an address is accepted, aw_ready stays 0 until the response for that transaction has been accepted.
- R4: The first flit of every packet has pk_head=1 and pk_tail=0, and its pk_data holds the address in bits [15:0], the size in [18:16], the burst length (beats minus one) in [22:19], the ID in [26:23] and zero above (default widths).
- R5: In cut-through mode w_ready stays 0 until the header flit has been accepted; each accepted beat then becomes one payload flit (pk_head=0) with the same data, in order, and pk_tail equal to that beat's w_last.
- R6: In store-and-forward mode no flit is offered before every beat of the burst has been accepted; the payload flits then carry the beats in order, with pk_tail=1 only on the last.
- R7: In store-and-forward mode a burst of more beats than DEPTH has all its beats accepted, produces no flit at all, and is answered with response code 2'b10.
- R8: Exactly one response is given per transaction, in the cycle after the tail flit (or the last drained beat) is accepted; b_id equals the accepted aw_id and b_resp is 2'b00 for a forwarded packet. No flit is offered and no beat is accepted while the response is pending.
- R9: A data beat presented before its address does not block the bridge: w_ready is 0 while aw_ready is 1, the address is still accepted and the transaction completes.
- R10: The mode (cut_thru=1 cut-through, 0 store-and-forward) is sampled in the address-accept cycle; later changes of cut_thru have no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cut_thru | input | 1 | Mode: 1 cut-through, 0 store-and-forward |
| aw_valid | input | 1 | Address channel valid |
| aw_ready | output | 1 | Address channel ready |
| aw_id | input | ID_W | Transaction ID |
| aw_addr | input | ADDR_W | Start address |
| aw_len | input | LEN_W | Burst length, beats minus one |
| aw_size | input | SIZE_W | Beat size code |
| w_valid | input | 1 | Data channel valid |
| w_ready | output | 1 | Data channel ready |
| w_data | input | DATA_W | Data beat |
| w_last | input | 1 | Final beat of burst |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response ready |
| b_id | output | ID_W | ID of the answered transaction |
| b_resp | output | 2 | 2'b00 accepted, 2'b10 refused |
| pk_valid | output | 1 | Flit valid |
| pk_ready | input | 1 | Flit ready |
| pk_data | output | DATA_W | Flit content |
| pk_head | output | 1 | Flit is a header |
| pk_tail | output | 1 | Flit ends the packet |

## Verification
The bound checker watches, on every cycle, the holding of stalled flits and responses, the closed address channel during a transaction, the exclusion of address and data readiness, the header never being tail, and the response following the tail flit. Content and ordering (header field packing, payload order in both modes, the refusal of oversized store-and-forward bursts, the ID echo, early data and a mode flip mid-transaction) can only be shown by the bench's sweep over every burst length in both modes under varying stall patterns.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_LIVE,
    ST_FILL,
    ST_DRAIN,
    ST_PLAY,
    ST_RESP
  } wpb_state_e;

  localparam logic [1:0] RESP_OK  = 2'b00;
  localparam logic [1:0] RESP_ERR = 2'b10;

endpackage

// File: rtl/wpb_hdr_pack.sv
module wpb_hdr_pack #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4,
  parameter int SIZE_W = 3,
  parameter int FLIT_W = 32
) (
  input  logic [ID_W-1:0]   id,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  output logic [FLIT_W-1:0] hdr
);
  // field offsets, address at the bottom, ID on top
  localparam int SIZE_LSB = ADDR_W;
  localparam int LEN_LSB  = SIZE_LSB + SIZE_W;
  localparam int ID_LSB   = LEN_LSB + LEN_W;

  always_comb begin
    hdr = '0;
    hdr[ADDR_W-1:0]         = addr;
    hdr[SIZE_LSB +: SIZE_W] = size;
    hdr[LEN_LSB +: LEN_W]   = len;
    hdr[ID_LSB +: ID_W]     = id;
  end
endmodule

// File: rtl/wpb_beat_buf.sv
module wpb_beat_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  // storage needs no reset: a slot is always written before it is read
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (32'(wr_idx) == g)) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/wpb_ctrl.sv
module wpb_ctrl
  import wpb_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cut_thru,
  input  logic             aw_valid,
  input  logic [LEN_W-1:0] aw_len,
  output logic             aw_ready,
  input  logic             w_valid,
  input  logic             w_last,
  output logic             w_ready,
  input  logic             b_ready,
  output logic             b_valid,
  output logic             b_err,
  input  logic             pk_ready,
  output logic             pk_valid,
  output logic             pk_head,
  output logic             pk_tail,
  output logic             pay_from_buf,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_widx,
  output logic [IDX_W-1:0] buf_ridx,
  output logic             cap_en
);
  wpb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rd_q, rd_d;
  logic             mode_q, mode_d;
  logic             err_q, err_d;
  logic             too_long;
  logic             play_last;
  logic             room;

  assign too_long  = 32'(aw_len) >= DEPTH;
  assign play_last = (rd_q + CNT_W'(1)) == cnt_q;
  assign room      = 32'(cnt_q) < DEPTH;
  assign buf_widx  = cnt_q[IDX_W-1:0];
  assign buf_ridx  = rd_q[IDX_W-1:0];
  assign b_err     = err_q;

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    rd_d         = rd_q;
    mode_d       = mode_q;
    err_d        = err_q;
    aw_ready     = 1'b0;
    w_ready      = 1'b0;
    b_valid      = 1'b0;
    pk_valid     = 1'b0;
    pk_head      = 1'b0;
    pk_tail      = 1'b0;
    pay_from_buf = 1'b0;
    buf_we       = 1'b0;
    cap_en       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        aw_ready = 1'b1;
        if (aw_valid) begin
          cap_en = 1'b1;
          mode_d = cut_thru;
          err_d  = !cut_thru && too_long;
          cnt_d  = '0;
          rd_d   = '0;
          if (cut_thru)      state_d = ST_HEAD;
          else if (too_long) state_d = ST_DRAIN;
          else               state_d = ST_FILL;
        end
      end
      ST_HEAD: begin
        pk_valid = 1'b1;
        pk_head  = 1'b1;
        if (pk_ready) state_d = mode_q ? ST_LIVE : ST_PLAY;
      end
      ST_LIVE: begin
        pk_valid = w_valid;
        pk_tail  = w_last;
        w_ready  = pk_ready;
        if (w_valid && pk_ready && w_last) state_d = ST_RESP;
      end
      ST_FILL: begin
        w_ready = 1'b1;
        if (w_valid) begin
          buf_we = room;
          if (room) cnt_d = cnt_q + CNT_W'(1);
          if (w_last) state_d = ST_HEAD;
        end
      end
      ST_DRAIN: begin
        w_ready = 1'b1;
        if (w_valid && w_last) state_d = ST_RESP;
      end
      ST_PLAY: begin
        pk_valid     = 1'b1;
        pay_from_buf = 1'b1;
        pk_tail      = play_last;
        if (pk_ready) begin
          rd_d = rd_q + CNT_W'(1);
          if (play_last) state_d = ST_RESP;
        end
      end
      ST_RESP: begin
        b_valid = 1'b1;
        if (b_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rd_q    <= '0;
      mode_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      mode_q  <= mode_d;
      err_q   <= err_d;
    end
  end
endmodule

// File: rtl/wr_pkt_bridge.sv
module wr_pkt_bridge
  import wpb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4,
  parameter int SIZE_W = 3,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cut_thru,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic [SIZE_W-1:0] aw_size,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [ID_W-1:0]   b_id,
  output logic [1:0]        b_resp,
  output logic              pk_valid,
  input  logic              pk_ready,
  output logic [DATA_W-1:0] pk_data,
  output logic              pk_head,
  output logic              pk_tail
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [SIZE_W-1:0] size_q;
  logic              cap_en;
  logic              b_err;
  logic              pay_from_buf;
  logic              buf_we;
  logic [IDX_W-1:0]  buf_widx;
  logic [IDX_W-1:0]  buf_ridx;
  logic [DATA_W-1:0] buf_rdata;
  logic [DATA_W-1:0] hdr_flit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      addr_q <= '0;
      len_q  <= '0;
      size_q <= '0;
    end else if (cap_en) begin
      id_q   <= aw_id;
      addr_q <= aw_addr;
      len_q  <= aw_len;
      size_q <= aw_size;
    end
  end

  wpb_ctrl #(.LEN_W(LEN_W), .DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cut_thru     (cut_thru),
    .aw_valid     (aw_valid),
    .aw_len       (aw_len),
    .aw_ready     (aw_ready),
    .w_valid      (w_valid),
    .w_last       (w_last),
    .w_ready      (w_ready),
    .b_ready      (b_ready),
    .b_valid      (b_valid),
    .b_err        (b_err),
    .pk_ready     (pk_ready),
    .pk_valid     (pk_valid),
    .pk_head      (pk_head),
    .pk_tail      (pk_tail),
    .pay_from_buf (pay_from_buf),
    .buf_we       (buf_we),
    .buf_widx     (buf_widx),
    .buf_ridx     (buf_ridx),
    .cap_en       (cap_en)
  );

  wpb_beat_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (buf_widx),
    .wr_data (w_data),
    .rd_idx  (buf_ridx),
    .rd_data (buf_rdata)
  );

  wpb_hdr_pack #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .FLIT_W(DATA_W)
  ) u_hdr (
    .id   (id_q),
    .addr (addr_q),
    .len  (len_q),
    .size (size_q),
    .hdr  (hdr_flit)
  );

  always_comb begin
    if (pk_head)           pk_data = hdr_flit;
    else if (pay_from_buf) pk_data = buf_rdata;
    else                   pk_data = w_data;
  end

  assign b_id   = id_q;
  assign b_resp = b_err ? RESP_ERR : RESP_OK;
endmodule

// File: rtl/wpb_checker.sv
module wpb_checker #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic              w_ready,
  input logic              b_valid,
  input logic              b_ready,
  input logic [ID_W-1:0]   b_id,
  input logic [1:0]        b_resp,
  input logic              pk_valid,
  input logic              pk_ready,
  input logic [DATA_W-1:0] pk_data,
  input logic              pk_head,
  input logic              pk_tail
);
  assert_flit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid && !pk_ready |=> pk_valid && $stable(pk_data) && $stable(pk_head) && $stable(pk_tail));

  assert_resp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid && !b_ready |=> b_valid && $stable(b_id) && $stable(b_resp));

  assert_addr_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && aw_ready |=> !aw_ready);

  assert_head_not_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid && pk_head |-> !pk_tail);

  assert_resp_after_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid && pk_ready && pk_tail |=> b_valid);

  assert_quiet_in_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> !pk_valid && !w_ready);

  assert_data_shut_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    aw_ready |-> !w_ready);
endmodule

bind wr_pkt_bridge wpb_checker #(.DATA_W(DATA_W), .ID_W(ID_W)) u_wpb_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .aw_valid (aw_valid),
  .aw_ready (aw_ready),
  .w_ready  (w_ready),
  .b_valid  (b_valid),
  .b_ready  (b_ready),
  .b_id     (b_id),
  .b_resp   (b_resp),
  .pk_valid (pk_valid),
  .pk_ready (pk_ready),
  .pk_data  (pk_data),
  .pk_head  (pk_head),
  .pk_tail  (pk_tail)
);

// File: tb/test_wr_pkt_bridge.sv
module test_wr_pkt_bridge;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int ID_W   = 4;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 4;
  localparam int SIZE_W = 3;
  localparam int DEPTH  = 8;

  logic clk, rst_n, cut_thru;
  logic aw_valid, aw_ready;
  logic [ID_W-1:0] aw_id;
  logic [ADDR_W-1:0] aw_addr;
  logic [LEN_W-1:0] aw_len;
  logic [SIZE_W-1:0] aw_size;
  logic w_valid, w_ready, w_last;
  logic [DATA_W-1:0] w_data;
  logic b_valid, b_ready;
  logic [ID_W-1:0] b_id;
  logic [1:0] b_resp;
  logic pk_valid, pk_ready, pk_head, pk_tail;
  logic [DATA_W-1:0] pk_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DATA_W-1:0] got_d [32];
  bit got_h [32];
  bit got_t [32];

  wr_pkt_bridge #(
    .DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH)
  ) i_wr_pkt_bridge (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] beat_val(input int t, input int k);
    return DATA_W'(32'hC000_0000 | (t << 8) | k);
  endfunction

  task automatic run_txn(input int t, input int len, input bit ct);
    int beats = len + 1;
    logic [ID_W-1:0] id = ID_W'(t);
    logic [ADDR_W-1:0] addr = ADDR_W'(t * 68 + 4);
    logic [SIZE_W-1:0] size = SIZE_W'(t);
    bit refuse = !ct && (beats > DEPTH);
    int aw_delay = (t % 4 == 2) ? 3 : 0;
    bit aw_done = 0, b_done = 0, w_pres = 0;
    bit bad_busy = 0, bad_ct = 0, bad_sf = 0;
    int k = 0, nfl = 0, bwait = 0, cyc = 0;
    logic [ID_W-1:0] rid = '0;
    logic [1:0] rresp = '0;
    logic [DATA_W-1:0] exp_hdr;
    int exp_n;
    while (!b_done && cyc < 400) begin
      @(negedge clk);
      aw_valid = !aw_done && (cyc >= aw_delay);
      aw_id = id; aw_addr = addr; aw_len = LEN_W'(len); aw_size = size;
      if (!w_pres && k < beats && (t % 2 == 0 || (cyc + t) % 4 != 0)) w_pres = 1;
      w_valid = w_pres;
      w_data = beat_val(t, k);
      w_last = (k == beats - 1);
      pk_ready = (t % 2 == 0) ? 1'b1 : ((cyc + t) % 3 != 0);
      b_ready = (t % 3 == 0) ? (bwait >= 2) : 1'b1;
      cut_thru = (aw_done && t % 4 == 3) ? !ct : ct;
      #(CLK_P/2 - 1);
      if (aw_done && aw_ready) bad_busy = 1;
      if (ct && w_ready && nfl == 0) bad_ct = 1;
      if (!ct && pk_valid && k < beats) bad_sf = 1;
      if (pk_valid && pk_ready && nfl < 32) begin
        got_d[nfl] = pk_data; got_h[nfl] = pk_head; got_t[nfl] = pk_tail; nfl++;
      end
      if (aw_valid && aw_ready) aw_done = 1;
      if (w_valid && w_ready) begin k++; w_pres = 0; end
      if (b_valid) begin
        if (b_ready) begin b_done = 1; rid = b_id; rresp = b_resp; end
        bwait++;
      end
      cyc++;
    end
    aw_valid = 0; w_valid = 0; w_last = 0;
    check(b_done, "R8 response returned", longint'(b_done), 1);
    if (t % 4 == 2) check(b_done && k == beats, "R9 early data completes", k, beats);
    check(rid == id, "R8 b_id echo", rid, id);
    check(rresp == (refuse ? 2'b10 : 2'b00), refuse ? "R7 error code" : "R8 ok code", rresp, refuse ? 2 : 0);
    check(!bad_busy, "R3 address closed while busy", bad_busy, 0);
    check(k == beats, "R2 all beats accepted", k, beats);
    exp_n = refuse ? 0 : beats + 1;
    check(nfl == exp_n, (t % 4 == 3) ? "R10 flit count after mode flip" :
          (refuse ? "R7 no flits" : "R6 flit count"), nfl, exp_n);
    if (ct) check(!bad_ct, "R5 data held until header", bad_ct, 0);
    else    check(!bad_sf, "R6 no flit before all beats", bad_sf, 0);
    if (!refuse && nfl == exp_n) begin
      exp_hdr = DATA_W'((int'(id) << 23) | (len << 19) | (int'(size) << 16) | int'(addr));
      check(got_h[0] && !got_t[0] && got_d[0] == exp_hdr, "R4 header flit", got_d[0], exp_hdr);
      for (int i = 1; i < exp_n; i++) begin
        check(!got_h[i] && got_d[i] == beat_val(t, i - 1) && got_t[i] == (i == exp_n - 1),
              ct ? "R5 payload flit" : "R6 payload flit", got_d[i], beat_val(t, i - 1));
      end
    end
  endtask

  initial begin
    rst_n = 0; cut_thru = 0;
    aw_valid = 0; aw_id = '0; aw_addr = '0; aw_len = '0; aw_size = '0;
    w_valid = 0; w_data = '0; w_last = 0; b_ready = 0; pk_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(aw_ready && !w_ready && !b_valid && !pk_valid, "R1 reset state",
          {aw_ready, w_ready, b_valid, pk_valid}, 4'b1000);
    for (int m = 0; m < 2; m++) begin
      for (int len = 0; len < (1 << LEN_W); len++) begin
        run_txn(m * 16 + len, len, m == 1);
      end
    end
    @(negedge clk);
    check(aw_ready && !b_valid && !pk_valid, "R1 idle after sweep", aw_ready, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule